// File: doc/BRIEF.md
# Audio FIFO Interrupt Aggregator

This block forms the interrupt and status logic of a serial-audio controller that has three stereo transmit channels and three stereo receive channels. For each channel it takes the FIFO level indications, the channel enable, and strobes that mark accesses to the left and right data registers. From these it keeps four registered interrupt sources per direction: one FIFO-level source for each channel, plus one underflow (transmit) or overflow (receive) source. Each direction has a two-bit control field. Bit 0 selects the FIFO trigger level and bit 1 gates the direction's combined interrupt.

The underflow and overflow sources stay set until the software has serviced every enabled channel of that direction. Servicing means writing both data registers on the transmit side and reading both on the receive side. A channel that is disabled counts as already serviced. Six sticky status bits capture the level and error sources. Software clears a sticky bit by writing zero to it, and a new set condition in the same cycle takes priority over the clear. A receive FIFO that runs empty only sets a status output and never raises an interrupt. The FIFOs, the serializer and the bus interface sit outside the block and appear here as plain inputs.

Top module: `afi_irq_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero one cycle later.
- R2: Each transmit source `tx_src[i]` (i = 0..2) registers, one cycle after its inputs, the value `tx_en[i] && (tx_ctl[0] ? tx_empty[i] : tx_half[i])`. Control bit 0 set to 1 means the empty trigger and 0 means the half-empty trigger. The source therefore drops when the FIFO is refilled.
- R3: Clearing `tx_en[i]` clears `tx_src[i]` on the next edge, whatever the FIFO level.
- R4: Each receive source `rx_src[i]` (i = 0..2) registers `rx_en[i] && (rx_ctl[0] ? rx_full[i] : rx_half[i])`. It drops when the FIFO falls below the selected level or when the channel is disabled.
- R5: `tx_src[3]` (underflow) sets the cycle after `tx_unf_evt`. It clears on the edge that follows the cycle in which every enabled transmit channel has had both `tx_wr_l` and `tx_wr_r` seen since the event. Writes made before the event do not count.
- R6: `rx_src[3]` (overflow) behaves the same way for `rx_ovf_evt`, using the read strobes `rx_rd_l` and `rx_rd_r`.
- R7: A disabled channel counts as serviced. Disabling the only outstanding channel therefore clears the error on the next edge, and an error raised with all channels of that direction disabled lasts one cycle.
- R8: `irq` equals `(tx_ctl[1] && |tx_src) || (rx_ctl[1] && |rx_src)` and is registered in the same cycle as the sources.
- R9: `sts` bit 0..5 records, in this order, TX2 level, TX underflow, RX0 level, RX1 level, RX2 level and RX overflow. A bit is set one cycle after its source's next value goes high and then holds.
- R10: With `sts_wr` high, each `sts` bit for which `sts_wdata` holds 0 clears. Writing 1 has no effect.
- R11: When a set condition and a write-zero clear hit the same sticky bit in the same cycle, the bit ends up set.
- R12: `rx_empty_sts[i]` follows `rx_empty[i]` with one cycle of delay. It never influences `rx_src` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ctl | input | 2 | Bit 0 trigger level (1 empty, 0 half), bit 1 TX interrupt enable |
| rx_ctl | input | 2 | Bit 0 trigger level (1 full, 0 half), bit 1 RX interrupt enable |
| tx_en | input | 3 | Transmit channel enables |
| tx_empty | input | 3 | Transmit FIFO empty per channel |
| tx_half | input | 3 | Transmit FIFO half empty per channel |
| tx_unf_evt | input | 1 | Transmit underflow event pulse |
| tx_wr_l | input | 3 | Left data register write strobes |
| tx_wr_r | input | 3 | Right data register write strobes |
| rx_en | input | 3 | Receive channel enables |
| rx_full | input | 3 | Receive FIFO full per channel |
| rx_half | input | 3 | Receive FIFO half full per channel |
| rx_empty | input | 3 | Receive FIFO empty per channel |
| rx_ovf_evt | input | 1 | Receive overflow event pulse |
| rx_rd_l | input | 3 | Left data register read strobes |
| rx_rd_r | input | 3 | Right data register read strobes |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 6 | Status write data for the sticky bits |
| tx_src | output | 4 | Transmit sources: bits 0..2 level, bit 3 underflow |
| rx_src | output | 4 | Receive sources: bits 0..2 level, bit 3 overflow |
| sts | output | 6 | Sticky status bits |
| rx_empty_sts | output | 3 | Receive FIFO empty status |
| irq | output | 1 | Combined controller interrupt |

## Verification
The bench uses the default of three channels per direction. With that setting the all-channels service rule for the error sources has to be tested over more than one enabled channel, and partial service (three of four strobes) must be seen to hold the error. The same width also makes the channel-2 sticky mapping reachable, along with the case where a disable removes the last outstanding channel.

// File: rtl/afi_pkg.sv
package afi_pkg;
  localparam int CTL_LVL  = 0;
  localparam int CTL_IEN  = 1;
  localparam int STK_W    = 6;
  localparam int STK_TX2  = 0;
  localparam int STK_TXU  = 1;
  localparam int STK_RX0  = 2;
  localparam int STK_RX1  = 3;
  localparam int STK_RX2  = 4;
  localparam int STK_RXO  = 5;
endpackage

// File: rtl/afi_level_src.sv
module afi_level_src #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lvl_sel,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] at_edge,
  input  logic [NCH-1:0] at_half,
  output logic [NCH-1:0] src_d,
  output logic [NCH-1:0] src_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb src_d[g] = ch_en[g] & (lvl_sel ? at_edge[g] : at_half[g]);

    always_ff @(posedge clk) begin
      if (rst) src_q[g] <= 1'b0;
      else     src_q[g] <= src_d[g];
    end

    AST_SRC_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
      !ch_en[g] |=> !src_q[g]); // R3
  end
endmodule

// File: rtl/afi_err_track.sv
module afi_err_track #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           evt,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] acc_l,
  input  logic [NCH-1:0] acc_r,
  output logic           err_d,
  output logic           err_q
);
  logic [NCH-1:0] seen_l_q, seen_r_q;
  logic [NCH-1:0] seen_l_n, seen_r_n;
  logic           all_done;

  always_comb begin
    seen_l_n = seen_l_q | acc_l;
    seen_r_n = seen_r_q | acc_r;
    all_done = &((seen_l_n & seen_r_n) | ~ch_en);
    if (evt)                  err_d = 1'b1;
    else if (err_q && all_done) err_d = 1'b0;
    else                      err_d = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= 1'b0;
      seen_l_q <= '0;
      seen_r_q <= '0;
    end else begin
      err_q <= err_d;
      if (evt || !err_q) begin
        seen_l_q <= '0;
        seen_r_q <= '0;
      end else begin
        seen_l_q <= seen_l_n;
        seen_r_q <= seen_r_n;
      end
    end
  end

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    evt |=> err_q); // R5
  AST_ERR_NOT_CLEARED_BY_EVT: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> !$past(evt)); // R6
  AST_ERR_HOLD_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    err_q && (acc_l == '0) && (acc_r == '0) && $stable(ch_en) && (seen_l_q == '0)
      && (ch_en != '0) |=> err_q); // R7
endmodule

// File: rtl/afi_sticky.sv
module afi_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                   q[b] <= 1'b0;
      else if (set_i[b])         q[b] <= 1'b1;
      else if (wr && !wdata[b])  q[b] <= 1'b0;
    end

    AST_STICKY_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> q[b]); // R11
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      q[b] && !(wr && !wdata[b]) |=> q[b]); // R10
  end
endmodule

// File: rtl/afi_irq_top.sv
module afi_irq_top
  import afi_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     tx_ctl,
  input  logic [1:0]     rx_ctl,
  input  logic [NCH-1:0] tx_en,
  input  logic [NCH-1:0] tx_empty,
  input  logic [NCH-1:0] tx_half,
  input  logic           tx_unf_evt,
  input  logic [NCH-1:0] tx_wr_l,
  input  logic [NCH-1:0] tx_wr_r,
  input  logic [NCH-1:0] rx_en,
  input  logic [NCH-1:0] rx_full,
  input  logic [NCH-1:0] rx_half,
  input  logic [NCH-1:0] rx_empty,
  input  logic           rx_ovf_evt,
  input  logic [NCH-1:0] rx_rd_l,
  input  logic [NCH-1:0] rx_rd_r,
  input  logic           sts_wr,
  input  logic [STK_W-1:0] sts_wdata,
  output logic [NCH:0]   tx_src,
  output logic [NCH:0]   rx_src,
  output logic [STK_W-1:0] sts,
  output logic [NCH-1:0] rx_empty_sts,
  output logic           irq
);
  localparam int LAST = NCH - 1;

  logic [NCH-1:0] tx_lvl_d, tx_lvl_q, rx_lvl_d, rx_lvl_q;
  logic           tx_unf_d, tx_unf_q, rx_ovf_d, rx_ovf_q;
  logic [STK_W-1:0] stk_set;
  logic           irq_d;

  afi_level_src #(.NCH(NCH)) u_tx_lvl (
    .clk(clk), .rst(rst), .lvl_sel(tx_ctl[CTL_LVL]), .ch_en(tx_en),
    .at_edge(tx_empty), .at_half(tx_half), .src_d(tx_lvl_d), .src_q(tx_lvl_q));

  afi_level_src #(.NCH(NCH)) u_rx_lvl (
    .clk(clk), .rst(rst), .lvl_sel(rx_ctl[CTL_LVL]), .ch_en(rx_en),
    .at_edge(rx_full), .at_half(rx_half), .src_d(rx_lvl_d), .src_q(rx_lvl_q));

  afi_err_track #(.NCH(NCH)) u_tx_unf (
    .clk(clk), .rst(rst), .evt(tx_unf_evt), .ch_en(tx_en),
    .acc_l(tx_wr_l), .acc_r(tx_wr_r), .err_d(tx_unf_d), .err_q(tx_unf_q));

  afi_err_track #(.NCH(NCH)) u_rx_ovf (
    .clk(clk), .rst(rst), .evt(rx_ovf_evt), .ch_en(rx_en),
    .acc_l(rx_rd_l), .acc_r(rx_rd_r), .err_d(rx_ovf_d), .err_q(rx_ovf_q));

  always_comb begin
    stk_set          = '0;
    stk_set[STK_TX2] = tx_lvl_d[LAST];
    stk_set[STK_TXU] = tx_unf_d;
    stk_set[STK_RX0] = rx_lvl_d[0];
    stk_set[STK_RX1] = rx_lvl_d[1 % NCH];
    stk_set[STK_RX2] = rx_lvl_d[LAST];
    stk_set[STK_RXO] = rx_ovf_d;
    irq_d = (tx_ctl[CTL_IEN] & (|tx_lvl_d | tx_unf_d))
          | (rx_ctl[CTL_IEN] & (|rx_lvl_d | rx_ovf_d));
  end

  afi_sticky #(.W(STK_W)) u_sticky (
    .clk(clk), .rst(rst), .set_i(stk_set), .wr(sts_wr), .wdata(sts_wdata), .q(sts));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq          <= 1'b0;
      rx_empty_sts <= '0;
    end else begin
      irq          <= irq_d;
      rx_empty_sts <= rx_empty;
    end
  end

  always_comb begin
    tx_src = {tx_unf_q, tx_lvl_q};
    rx_src = {rx_ovf_q, rx_lvl_q};
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !tx_ctl[CTL_IEN] && !rx_ctl[CTL_IEN] |=> !irq); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|tx_src) || (|rx_src)); // R8
  AST_RX_EMPTY_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (rx_src == '0) && (tx_src == '0) |-> !irq); // R12
endmodule

// File: tb/afi_irq_top_tb.sv
module afi_irq_top_tb;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0] tx_ctl = '0, rx_ctl = '0;
  logic [NCH-1:0] tx_en = '0, tx_empty = '0, tx_half = '0, tx_wr_l = '0, tx_wr_r = '0;
  logic [NCH-1:0] rx_en = '0, rx_full = '0, rx_half = '0, rx_empty = '0, rx_rd_l = '0, rx_rd_r = '0;
  logic tx_unf_evt = 1'b0, rx_ovf_evt = 1'b0, sts_wr = 1'b0;
  logic [5:0] sts_wdata = '0;
  logic [NCH:0] tx_src, rx_src;
  logic [5:0] sts;
  logic [NCH-1:0] rx_empty_sts;
  logic irq;

  afi_irq_top #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .tx_ctl(tx_ctl), .rx_ctl(rx_ctl),
    .tx_en(tx_en), .tx_empty(tx_empty), .tx_half(tx_half), .tx_unf_evt(tx_unf_evt),
    .tx_wr_l(tx_wr_l), .tx_wr_r(tx_wr_r), .rx_en(rx_en), .rx_full(rx_full),
    .rx_half(rx_half), .rx_empty(rx_empty), .rx_ovf_evt(rx_ovf_evt),
    .rx_rd_l(rx_rd_l), .rx_rd_r(rx_rd_r), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .tx_src(tx_src), .rx_src(rx_src), .sts(sts), .rx_empty_sts(rx_empty_sts), .irq(irq));

  typedef struct packed {
    logic [NCH:0]   tx;
    logic [NCH:0]   rx;
    logic [5:0]     st;
    logic [NCH-1:0] re;
    logic           ir;
  } obs_t;

  obs_t   exp_q[$];
  string  tag_q[$];
  int     total = 0, bad = 0;

  logic [NCH:0]   m_tx = '0, m_rx = '0;
  logic [5:0]     m_st = '0;
  logic [NCH-1:0] m_re = '0;
  logic           m_ir = 1'b0;
  logic [NCH-1:0] tl = '0, tr = '0, rl = '0, rr = '0;

  // Reference model built from the requirements; pushes one expectation per cycle.
  task automatic tick(input string tag);
    logic [NCH-1:0] ntx, nrx, nl, nr;
    logic ntu, nro;
    logic [5:0] set;
    obs_t e;
    if (rst) begin
      m_tx = '0; m_rx = '0; m_st = '0; m_re = '0; m_ir = 1'b0;
      tl = '0; tr = '0; rl = '0; rr = '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        ntx[i] = tx_en[i] && (tx_ctl[0] ? tx_empty[i] : tx_half[i]);
        nrx[i] = rx_en[i] && (rx_ctl[0] ? rx_full[i] : rx_half[i]);
      end
      nl = tl | tx_wr_l; nr = tr | tx_wr_r;
      if (tx_unf_evt) ntu = 1'b1;
      else if (m_tx[NCH] && (&((nl & nr) | ~tx_en))) ntu = 1'b0;
      else ntu = m_tx[NCH];
      if (tx_unf_evt || !m_tx[NCH]) begin tl = '0; tr = '0; end else begin tl = nl; tr = nr; end
      nl = rl | rx_rd_l; nr = rr | rx_rd_r;
      if (rx_ovf_evt) nro = 1'b1;
      else if (m_rx[NCH] && (&((nl & nr) | ~rx_en))) nro = 1'b0;
      else nro = m_rx[NCH];
      if (rx_ovf_evt || !m_rx[NCH]) begin rl = '0; rr = '0; end else begin rl = nl; rr = nr; end
      set = {nro, nrx[2], nrx[1], nrx[0], ntu, ntx[2]};
      m_st = set | (sts_wr ? (m_st & sts_wdata) : m_st);
      m_ir = (tx_ctl[1] && (|{ntu, ntx})) || (rx_ctl[1] && (|{nro, nrx}));
      m_tx = {ntu, ntx}; m_rx = {nro, nrx}; m_re = rx_empty;
    end
    e.tx = m_tx; e.rx = m_rx; e.st = m_st; e.re = m_re; e.ir = m_ir;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    tx_unf_evt = 0; rx_ovf_evt = 0; sts_wr = 0;
    tx_wr_l = '0; tx_wr_r = '0; rx_rd_l = '0; rx_rd_r = '0;
  endtask

  // Monitor: compares every registered output one step after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      obs_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.tx = tx_src; a.rx = rx_src; a.st = sts; a.re = rx_empty_sts; a.ir = irq;
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: actual tx=%b rx=%b sts=%b re=%b irq=%b expected tx=%b rx=%b sts=%b re=%b irq=%b",
                 t, a.tx, a.rx, a.st, a.re, a.ir, e.tx, e.rx, e.st, e.re, e.ir);
      end
    end
  end

  // Dedicated point checks on individual outputs.
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; tick("R1 reset"); tick("R1 reset");
    rst = 0;
    chk("R1 irq after reset", {7'd0, irq}, 8'd0);
    // R2: empty trigger, then half trigger
    tx_en = 3'b001; tx_ctl = 2'b11; tx_empty = 3'b001; tick("R2 empty trig");
    chk("R2 src0 set", {4'd0, tx_src}, 8'h1);
    tx_empty = 3'b000; tx_half = 3'b001; tick("R2 half ignored at empty level");
    chk("R2 refilled", {4'd0, tx_src}, 8'h0);
    tx_ctl = 2'b10; tick("R2 half trig");
    chk("R8 irq from tx", {7'd0, irq}, 8'd1);
    tx_ctl = 2'b00; tick("R8 tx irq gated");
    chk("R8 gated irq", {7'd0, irq}, 8'd0);
    // R3: disable clears
    tx_en = 3'b000; tick("R3 disable clears");
    tx_half = '0;
    // R4 / R12
    rx_ctl = 2'b11; rx_en = 3'b111; rx_empty = 3'b111; tick("R12 rx empty status only");
    chk("R12 no irq from rx empty", {7'd0, irq}, 8'd0);
    chk("R12 status", {5'd0, rx_empty_sts}, 8'h7);
    rx_empty = '0; rx_full = 3'b010; tick("R4 full trig");
    rx_full = '0; rx_half = 3'b010; tick("R4 below full clears");
    rx_ctl = 2'b10; tick("R4 half trig");
    rx_en = 3'b101; tick("R4 disable clears");
    rx_half = '0; rx_ctl = 2'b00;
    sts_wr = 1; sts_wdata = 6'b000000; tick("R10 clear all");
    chk("R10 cleared", {2'd0, sts}, 8'h0);
    // R5: underflow with two enabled channels
    tx_en = 3'b011; tx_wr_l = 3'b011; tx_wr_r = 3'b011; tick("R5 early writes");
    tx_unf_evt = 1; tick("R5 set");
    chk("R5 underflow set", {7'd0, tx_src[3]}, 8'd1);
    tx_wr_l = 3'b001; tick("R5 partial");
    tx_wr_r = 3'b001; tx_wr_l = 3'b010; tick("R5 partial 3 of 4");
    chk("R5 still set", {7'd0, tx_src[3]}, 8'd1);
    tx_wr_r = 3'b010; tick("R5 final write");
    chk("R5 cleared", {7'd0, tx_src[3]}, 8'd0);
    // R6 / R7: overflow, disable removes last outstanding channel
    rx_en = 3'b110; rx_ovf_evt = 1; tick("R6 set");
    rx_rd_l = 3'b110; rx_rd_r = 3'b010; tick("R6 partial");
    chk("R6 still set", {7'd0, rx_src[3]}, 8'd1);
    tick("R6 holds");
    rx_en = 3'b010; tick("R7 disable outstanding");
    chk("R7 overflow cleared", {7'd0, rx_src[3]}, 8'd0);
    tx_en = 3'b000; tx_unf_evt = 1; tick("R7 all disabled set");
    tick("R7 all disabled clears");
    chk("R7 one-cycle error", {7'd0, tx_src[3]}, 8'd0);
    // R9 / R10 / R11: sticky behaviour
    tx_en = 3'b100; tx_ctl = 2'b01; tx_empty = 3'b100; tick("R9 tx2 sets sticky");
    tx_empty = '0; tick("R9 holds");
    chk("R9 tx2 sticky", {7'd0, sts[0]}, 8'd1);
    tx_empty = 3'b100; sts_wr = 1; sts_wdata = 6'b000000; tick("R11 set wins");
    chk("R11 set wins", {7'd0, sts[0]}, 8'd1);
    tx_empty = '0; sts_wr = 1; sts_wdata = 6'b111111; tick("R10 write one no effect");
    chk("R10 write one", {7'd0, sts[0]}, 8'd1);
    sts_wr = 1; sts_wdata = 6'b111110; tick("R10 write zero clears");
    chk("R10 write zero", {2'd0, sts}, 8'h2 & {2'd0, sts});
    rx_en = 3'b111; rx_ctl = 2'b11; rx_full = 3'b101; tick("R9 rx0 rx2 sticky");
    rx_full = '0; tick("R9 rx hold");
    tx_ctl = 2'b10; rx_ctl = 2'b10; tick("R8 idle");
    chk("R8 no source no irq", {7'd0, irq}, 8'd0);
    @(posedge clk); #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule